// File: doc/BRIEF.md
# I2C Target Address Matcher and Receiver

This block is the receive side of a 7-bit I2C target. It samples the raw SCL and SDA lines into the system clock, finds START and STOP conditions, shifts in the calling address with its read/write bit, and decides whether to acknowledge. It answers its programmed own address. When the general-call enable is set, it also answers the all-zero general-call address. Once addressed for a write, it acknowledges and stores each data byte that follows. The block only asks for SDA to be pulled low. The open-drain pad sits outside the block.

Software sees a small status set: transfer complete, addressed, direction, and arbitration lost. Arbitration lost is reported by the master logic through a one-cycle input pulse. Software also sees the last received byte. The first byte after a match is the address byte itself, so a value of 0x00 marks a general call. Three events raise one interrupt flag: a byte completes, an address matches, or arbitration is lost. An enable masks that flag onto the interrupt output, and software clears the flag by writing 1.

The control path is a single state machine:
- **ST_IDLE**: no transfer is in progress.
- **ST_ADDR**: shifts in the address byte.
- **ST_ADDR_ACK**: drives the address acknowledge.
- **ST_DATA**: shifts in a data byte.
- **ST_DATA_ACK**: drives the data acknowledge.
- **ST_HOLD**: ignores bus traffic until the next START or STOP.

Its transitions are:
- From any state, START goes to ST_ADDR.
- From any state, STOP or a cleared enable goes to ST_IDLE.
- From ST_ADDR, on the eighth SCL falling edge, a hit goes to ST_ADDR_ACK and a miss goes to ST_HOLD.
- From ST_ADDR_ACK, on the ninth SCL falling edge, a write goes to ST_DATA and a read goes to ST_HOLD.
- From ST_DATA, on the eighth SCL falling edge, the machine goes to ST_DATA_ACK.
- From ST_DATA_ACK, on the ninth SCL falling edge, the machine returns to ST_DATA.

Top module: `i2c_target_matcher`

## Requirements
- R1: After reset every flag, `rx_data` and `sda_pull` are 0. While `cfg_enable` is 0 the block acknowledges nothing and raises no flag.
- R2: A START is SDA falling while SCL is high, and it begins an address phase. A STOP (SDA rising while SCL is high) or a repeated START clears `flag_aas` and ends the current transfer.
- R3: The first byte after START is taken MSB first. Bits 7..1 are the calling address and bit 0 is R/W (1 = read). If the calling address equals `cfg_own_addr`, `sda_pull` is 1 from the eighth SCL falling edge to the ninth SCL falling edge.
- R4: A calling address of 0 with R/W = 0 is acknowledged only when `cfg_gc_en` is 1. When `cfg_gc_en` is 0 it gets no acknowledge, and the data bytes after it are neither acknowledged nor stored.
- R5: A calling address that does not match gets no acknowledge and sets no flag.
- R6: `flag_aas` rises at the ninth SCL falling edge of a matched address byte. At that point `flag_srw` holds the received R/W bit. After a read match, no further bytes are acknowledged.
- R7: After a match, `rx_data` holds the whole address byte (0x00 for a general call). Each later data byte of a write is acknowledged and loaded into `rx_data`.
- R8: `flag_tcf` rises at the ninth SCL falling edge of every acknowledged byte. It falls at the next bit's SCL rising edge, or at START or STOP.
- R9: `irq_flag` is set when a byte completes, when an address matches, or when `arb_lost_i` pulses. The output `irq` is `irq_flag` masked by `cfg_irq_en`.
- R10: A write (`stat_wr` = 1) with `stat_w1c[0]` = 1 clears `irq_flag`, and one with `stat_w1c[1]` = 1 clears `flag_arbl`. Zero bits have no effect. A set event in the same cycle as a clear wins.
- R11: An `arb_lost_i` pulse sets `flag_arbl`, which stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull | output | 1 | 1 requests SDA driven low (acknowledge) |
| cfg_enable | input | 1 | Block enable |
| cfg_gc_en | input | 1 | General-call match enable |
| cfg_irq_en | input | 1 | Interrupt output mask |
| cfg_own_addr | input | 7 | Programmed own address |
| arb_lost_i | input | 1 | One-cycle arbitration-lost event |
| stat_wr | input | 1 | Status write strobe |
| stat_w1c | input | 2 | Write-1-to-clear data: bit0 irq_flag, bit1 flag_arbl |
| rx_data | output | 8 | Last received byte |
| flag_tcf | output | 1 | Byte transfer complete |
| flag_aas | output | 1 | Addressed as target |
| flag_srw | output | 1 | R/W bit of the last match |
| flag_arbl | output | 1 | Arbitration lost |
| irq_flag | output | 1 | Combined interrupt flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check the following on every cycle:
- the acknowledge pull-down starts and ends only on an SCL falling edge or a bus reset event;
- `flag_tcf` rises only after an SCL falling edge, and `flag_aas` rises together with it;
- START and STOP clear `flag_aas`;
- the interrupt flag rises only from one of its three sources and stays set until it is cleared;
- disabling releases SDA.

Only the directed scenarios can show that the block's decisions are correct:
- which addresses are matched;
- the general-call on/off behaviour;
- the exact byte captured in `rx_data`;
- the direction bit;
- that data after a refused general call is left untouched.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int W1C_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_HOLD
    } tm_state_t;
endpackage

// File: rtl/i2c_tm_sync.sv
module i2c_tm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_tm_edges.sv
module i2c_tm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tm_fsm.sv
module i2c_tm_fsm
    import i2c_tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic [DATA_W-1:0] rx_data,
    output logic              srw,
    output logic              ev_byte_done,
    output logic              ev_addr_match,
    output logic              ev_shift,
    output logic              ev_bus_reset
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    tm_state_t         state;
    tm_state_t         nxt;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              byte_full;
    logic              is_gc;
    logic              hit;
    logic              shifting;

    assign byte_full = (cnt_q == FULL);
    assign is_gc     = (sh_q[DATA_W-1:1] == '0);
    assign hit       = is_gc ? (gc_en && !sh_q[0])
                             : (sh_q[DATA_W-1:1] == own_addr);
    assign shifting  = (state == ST_ADDR || state == ST_DATA) && scl_rise && !byte_full;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full) nxt = hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall) nxt = sh_q[0] ? ST_HOLD : ST_DATA;
                ST_DATA:     if (scl_fall && byte_full) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                ST_HOLD:     nxt = ST_HOLD;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            rx_data <= '0;
            srw     <= 1'b0;
        end else begin
            if (start_det) begin
                cnt_q <= '0;
            end else if (shifting) begin
                sh_q  <= {sh_q[DATA_W-2:0], sda_s};
                cnt_q <= cnt_q + 1'b1;
            end else if ((state == ST_ADDR_ACK || state == ST_DATA_ACK) && scl_fall) begin
                cnt_q <= '0;
            end
            if (enable && !start_det && !stop_det && scl_fall && byte_full) begin
                if (state == ST_ADDR && hit) begin
                    rx_data <= sh_q;
                    srw     <= sh_q[0];
                end else if (state == ST_DATA) begin
                    rx_data <= sh_q;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull      = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
        ev_addr_match = enable && (state == ST_ADDR_ACK) && scl_fall;
        ev_byte_done  = enable && sda_pull && scl_fall;
        ev_shift      = shifting;
        ev_bus_reset  = start_det || stop_det || !enable;
    end
endmodule

// File: rtl/i2c_tm_flags.sv
module i2c_tm_flags
    import i2c_tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_byte_done,
    input  logic             ev_addr_match,
    input  logic             ev_shift,
    input  logic             ev_bus_reset,
    input  logic             arb_lost_i,
    input  logic             stat_wr,
    input  logic [W1C_W-1:0] stat_w1c,
    input  logic             irq_en,
    output logic             tcf,
    output logic             aas,
    output logic             arbl,
    output logic             irq_flag,
    output logic             irq
);
    logic any_src;

    assign any_src = ev_byte_done || ev_addr_match || arb_lost_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcf      <= 1'b0;
            aas      <= 1'b0;
            arbl     <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (ev_byte_done)                   tcf <= 1'b1;
            else if (ev_shift || ev_bus_reset)  tcf <= 1'b0;

            if (ev_addr_match)      aas <= 1'b1;
            else if (ev_bus_reset)  aas <= 1'b0;

            if (arb_lost_i)                    arbl <= 1'b1;
            else if (stat_wr && stat_w1c[1])   arbl <= 1'b0;

            if (any_src)                       irq_flag <= 1'b1;
            else if (stat_wr && stat_w1c[0])   irq_flag <= 1'b0;
        end
    end

    assign irq = irq_flag && irq_en;
endmodule

// File: rtl/i2c_target_matcher.sv
module i2c_target_matcher
    import i2c_tm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              cfg_enable,
    input  logic              cfg_gc_en,
    input  logic              cfg_irq_en,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic              arb_lost_i,
    input  logic              stat_wr,
    input  logic [W1C_W-1:0]  stat_w1c,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_tcf,
    output logic              flag_aas,
    output logic              flag_srw,
    output logic              flag_arbl,
    output logic              irq_flag,
    output logic              irq
);
    logic [1:0] bus_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       ev_byte_done;
    logic       ev_addr_match;
    logic       ev_shift;
    logic       ev_bus_reset;

    i2c_tm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );

    i2c_tm_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (cfg_enable),
        .gc_en         (cfg_gc_en),
        .own_addr      (cfg_own_addr),
        .sda_s         (bus_s[0]),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .sda_pull      (sda_pull),
        .rx_data       (rx_data),
        .srw           (flag_srw),
        .ev_byte_done  (ev_byte_done),
        .ev_addr_match (ev_addr_match),
        .ev_shift      (ev_shift),
        .ev_bus_reset  (ev_bus_reset)
    );

    i2c_tm_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_byte_done  (ev_byte_done),
        .ev_addr_match (ev_addr_match),
        .ev_shift      (ev_shift),
        .ev_bus_reset  (ev_bus_reset),
        .arb_lost_i    (arb_lost_i),
        .stat_wr       (stat_wr),
        .stat_w1c      (stat_w1c),
        .irq_en        (cfg_irq_en),
        .tcf           (flag_tcf),
        .aas           (flag_aas),
        .arbl          (flag_arbl),
        .irq_flag      (irq_flag),
        .irq           (irq)
    );
endmodule

// File: rtl/i2c_tm_checker.sv
module i2c_tm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       arb_lost_i,
    input logic       stat_wr,
    input logic [1:0] stat_w1c,
    input logic       sda_pull,
    input logic       flag_tcf,
    input logic       flag_aas,
    input logic       flag_arbl,
    input logic       irq_flag,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det
);
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sda_pull);

    p_aas_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !flag_aas);

    p_pull_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    p_pull_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det) || $past(!enable)));

    p_aas_with_tcf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_aas) |-> flag_tcf);

    p_tcf_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_tcf) |-> $past(scl_fall));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(arb_lost_i) || $rose(flag_tcf) || $rose(flag_aas)));

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(stat_wr && stat_w1c[0])) |=> irq_flag);

    p_arbl_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_i |=> (flag_arbl && irq_flag));
endmodule

bind i2c_target_matcher i2c_tm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .arb_lost_i (arb_lost_i),
    .stat_wr    (stat_wr),
    .stat_w1c   (stat_w1c),
    .sda_pull   (sda_pull),
    .flag_tcf   (flag_tcf),
    .flag_aas   (flag_aas),
    .flag_arbl  (flag_arbl),
    .irq_flag   (irq_flag),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det)
);

// File: tb/tb_i2c_target_matcher.sv
module tb_i2c_target_matcher;
    localparam int Q    = 20;
    localparam int WDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_pull;
    logic       cfg_enable = 1'b0;
    logic       cfg_gc_en = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic [6:0] cfg_own_addr = 7'h3A;
    logic       arb_lost_i = 1'b0;
    logic       stat_wr = 1'b0;
    logic [1:0] stat_w1c = 2'b00;
    logic [7:0] rx_data;
    logic       flag_tcf, flag_aas, flag_srw, flag_arbl, irq_flag, irq;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_target_matcher dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull(sda_pull), .cfg_enable(cfg_enable), .cfg_gc_en(cfg_gc_en),
        .cfg_irq_en(cfg_irq_en), .cfg_own_addr(cfg_own_addr),
        .arb_lost_i(arb_lost_i), .stat_wr(stat_wr), .stat_w1c(stat_w1c),
        .rx_data(rx_data), .flag_tcf(flag_tcf), .flag_aas(flag_aas),
        .flag_srw(flag_srw), .flag_arbl(flag_arbl), .irq_flag(irq_flag), .irq(irq)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(2*Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic tcf_mid);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(2*Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        acked   = !sda_bus;
        tcf_mid = flag_tcf;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic w1c(input logic [1:0] bits);
        stat_wr = 1'b1; stat_w1c = bits; wait_clk(1);
        stat_wr = 1'b0; stat_w1c = 2'b00; wait_clk(1);
    endtask

    task automatic t_reset();
        logic a, t;
        chk("R1", "tcf after reset", flag_tcf, 0);
        chk("R1", "aas after reset", flag_aas, 0);
        chk("R1", "irq_flag after reset", irq_flag, 0);
        chk("R1", "arbl/sda_pull/rx after reset", {flag_arbl, sda_pull, rx_data}, 0);
        bus_start();
        send_byte(8'h74, a, t);
        chk("R1", "ack while disabled", a, 0);
        chk("R1", "flags while disabled", {flag_aas, flag_tcf, irq_flag}, 0);
        bus_stop();
    endtask

    task automatic t_own_write();
        logic a, t;
        cfg_enable = 1'b1; cfg_irq_en = 1'b1; wait_clk(4);
        bus_start();
        send_byte(8'h74, a, t);
        chk("R3", "own address ack", a, 1);
        chk("R8", "tcf before 9th fall (address)", t, 0);
        chk("R6", "aas after match", flag_aas, 1);
        chk("R6", "srw after write match", flag_srw, 0);
        chk("R8", "tcf after address byte", flag_tcf, 1);
        chk("R7", "rx holds address byte", rx_data, 8'h74);
        chk("R9", "irq flag and output", {irq_flag, irq}, 2'b11);
        w1c(2'b01);
        chk("R10", "irq flag cleared by w1c", irq_flag, 0);
        send_byte(8'hA5, a, t);
        chk("R7", "data byte ack", a, 1);
        chk("R8", "tcf cleared during next byte", t, 0);
        chk("R8", "tcf after data byte", flag_tcf, 1);
        chk("R7", "rx data A5", rx_data, 8'hA5);
        chk("R9", "irq from byte complete", irq_flag, 1);
        send_byte(8'h3C, a, t);
        chk("R7", "rx data 3C", rx_data, 8'h3C);
        bus_stop();
        chk("R2", "aas cleared by stop", flag_aas, 0);
        chk("R8", "tcf cleared by stop", flag_tcf, 0);
        w1c(2'b01);
    endtask

    task automatic t_read();
        logic a, t;
        bus_start();
        send_byte(8'h75, a, t);
        chk("R6", "read address ack", a, 1);
        chk("R6", "srw after read match", {flag_srw, flag_aas}, 2'b11);
        send_byte(8'hFF, a, t);
        chk("R6", "no ack after read match", a, 0);
        bus_stop();
        w1c(2'b01);
    endtask

    task automatic t_gc_on();
        logic a, t;
        cfg_gc_en = 1'b1;
        bus_start();
        send_byte(8'h00, a, t);
        chk("R4", "general call ack when enabled", a, 1);
        chk("R7", "rx 00 marks general call", rx_data, 8'h00);
        chk("R6", "aas after general call", flag_aas, 1);
        send_byte(8'h5A, a, t);
        chk("R4", "general call data ack", a, 1);
        chk("R7", "general call data stored", rx_data, 8'h5A);
        bus_stop();
        w1c(2'b01);
    endtask

    task automatic t_gc_off();
        logic a, t;
        cfg_gc_en = 1'b0;
        bus_start();
        send_byte(8'h00, a, t);
        chk("R4", "general call refused", a, 0);
        chk("R4", "no flags on refused general call", {flag_aas, flag_tcf, irq_flag}, 0);
        send_byte(8'h66, a, t);
        chk("R4", "data after refused gc not acked", a, 0);
        chk("R4", "rx unchanged after refused gc", rx_data, 8'h5A);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a, t;
        bus_start();
        send_byte(8'h44, a, t);
        chk("R5", "mismatch no ack", a, 0);
        chk("R5", "mismatch no flags", {flag_aas, flag_tcf, irq_flag}, 0);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a, t;
        bus_start();
        send_byte(8'h74, a, t);
        chk("R2", "ack before repeated start", {a, flag_aas}, 2'b11);
        bus_start();
        chk("R2", "aas cleared by repeated start", flag_aas, 0);
        send_byte(8'h44, a, t);
        chk("R2", "new address phase after restart", a, 0);
        bus_stop();
        w1c(2'b01);
    endtask

    task automatic t_irq_mask();
        logic a, t;
        cfg_irq_en = 1'b0;
        bus_start();
        send_byte(8'h74, a, t);
        chk("R9", "masked irq", {irq_flag, irq}, 2'b10);
        cfg_irq_en = 1'b1; wait_clk(1);
        chk("R9", "unmasked irq", irq, 1);
        bus_stop();
        w1c(2'b01);
        chk("R10", "irq output after clear", irq, 0);
    endtask

    task automatic t_arb();
        arb_lost_i = 1'b1; wait_clk(1);
        arb_lost_i = 1'b0;
        chk("R11", "arbl and irq set", {flag_arbl, irq_flag}, 2'b11);
        w1c(2'b00);
        chk("R10", "zero write no effect", {flag_arbl, irq_flag}, 2'b11);
        w1c(2'b01);
        chk("R10", "irq cleared, arbl held", {flag_arbl, irq_flag}, 2'b10);
        w1c(2'b10);
        chk("R11", "arbl cleared", flag_arbl, 0);
        arb_lost_i = 1'b1; stat_wr = 1'b1; stat_w1c = 2'b01; wait_clk(1);
        arb_lost_i = 1'b0; stat_wr = 1'b0; stat_w1c = 2'b00;
        chk("R10", "set wins over clear", irq_flag, 1);
        w1c(2'b11);
        chk("R10", "both cleared", {flag_arbl, irq_flag}, 2'b00);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_own_write();
        t_read();
        t_gc_on();
        t_gc_off();
        t_mismatch();
        t_restart();
        t_irq_mask();
        t_arb();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule